// File: doc/BRIEF.md
# Clarke Input Conditioner

This block turns one set of sampled phase values into an orthogonal pair (a cosine component and a sine component) with signed fixed-point arithmetic. It sits in front of a vector rotator in a motor-control or power-measurement datapath. The pair it produces is also a primary output of the block, so logic that needs the stationary-frame signal can use it before any angle rotation is applied.

Three input formats are supported and are chosen per sample by a two-bit format code. In the first, the caller already supplies a quadrature pair and the block forwards it. In the second, three phases spaced 120° apart (a = cos θ, b = cos(θ+120°), c = cos(θ+240°)) are supplied. In the third, only phases b and c are wired and the block rebuilds phase a from them, using the fact that a balanced set sums to zero. One sample set is taken on each cycle with `smp_vld` high. The matching result appears with its own valid flag exactly two clock cycles later. Intermediate values that exceed the 16-bit range are clamped, never wrapped.

Top module: `clarke_cond`

## Requirements
- R1: While `rst_n` is low and after its release, until the first accepted sample, `orth_vld` and `fmt_err` are 0 and `orth_cos`, `orth_sin` are 0.
- R2: A sample taken with `smp_vld` = 1 and a valid format code gives exactly one cycle with `orth_vld` = 1, at the second rising clock edge after the one that sampled it; back-to-back samples give back-to-back results.
- R3: Format code 2'b01 (quadrature): `orth_cos` = `ph_a` and `orth_sin` = `quad_sin`, unchanged; `ph_b` and `ph_c` have no effect.
- R4: Format code 2'b10 (three phases): `orth_cos` = `ph_a` and `orth_sin` = floor(((`ph_c` − `ph_b`) × 18919 + 16384) / 32768), with 18919 the Q15 value of 1/√3; `quad_sin` has no effect.
- R5: Format code 2'b11 (two phases): phase a is rebuilt as −(`ph_b` + `ph_c`), `orth_cos` is that value clamped, `orth_sin` follows the R4 formula; `ph_a` and `quad_sin` have no effect.
- R6: Every computed result is clamped to the range −32768..32767 (for example b = c = −32768 in format 2'b11 gives `orth_cos` = 32767).
- R7: Format code 2'b00 is invalid: a sample carrying it gives `fmt_err` = 1 for one cycle at the time a result would have appeared, `orth_vld` stays 0 and the output pair keeps its previous value.
- R8: When `orth_vld` is 0 the output pair holds its last value, and input values presented with `smp_vld` = 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | Sample strobe, one set of inputs taken per high cycle |
| fmt_sel | input | 2 | Format code: 01 quadrature, 10 three phases, 11 phases b and c only, 00 invalid |
| ph_a | input | 16 | Phase a, or the cosine input in quadrature format (two's complement) |
| ph_b | input | 16 | Phase b (two's complement) |
| ph_c | input | 16 | Phase c (two's complement) |
| quad_sin | input | 16 | Sine input in quadrature format (two's complement) |
| orth_vld | output | 1 | Result strobe, two cycles after an accepted sample |
| fmt_err | output | 1 | Pulse for a sample that carried the invalid format code |
| orth_cos | output | 16 | Cosine component of the orthogonal pair |
| orth_sin | output | 16 | Sine component of the orthogonal pair |

## Verification
A wrong stage-one register shows up at the ports on the very next result: a mis-decoded format leaves a wrong `orth_cos` or `orth_sin` two cycles after the offending sample, and a lost or duplicated valid bit moves or doubles `orth_vld` in that same cycle. Errors in the rebuild sum or the 1/√3 product surface as value mismatches at full-scale inputs, where the clamp must engage instead of wrapping. A capture enable that ignores `smp_vld` is caught on the first idle cycle, because junk driven while idle would alter the held output pair.

// File: rtl/clarke_pkg.sv
package clarke_pkg;

  typedef enum logic [1:0] {
    FMT_NONE = 2'b00,
    FMT_QUAD = 2'b01,
    FMT_TRI  = 2'b10,
    FMT_DUO  = 2'b11
  } fmt_e;

  // Clamp a wide signed value into a w-bit two's complement range.
  function automatic logic signed [63:0] sat_w(input logic signed [63:0] v, input int w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Multiply by a Qfrac constant and shift back, with optional round-half-up.
  function automatic logic signed [63:0] mul_q(input logic signed [63:0] d,
                                               input logic signed [63:0] k,
                                               input int frac,
                                               input bit rnd);
    logic signed [63:0] p;
    p = d * k;
    if (rnd) p = p + (64'sd1 <<< (frac - 1));
    return p >>> frac;
  endfunction

  function automatic bit fmt_ok(input fmt_e f);
    return f != FMT_NONE;
  endfunction

endpackage

// File: rtl/clarke_front.sv
module clarke_front
  import clarke_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic [1:0]          fmt_sel,
  input  logic signed [W-1:0] ph_a,
  input  logic signed [W-1:0] ph_b,
  input  logic signed [W-1:0] ph_c,
  input  logic signed [W-1:0] quad_sin,
  output logic                s1_vld,
  output logic                s1_err,
  output fmt_e                s1_fmt,
  output logic signed [W-1:0] s1_cos,
  output logic signed [W:0]   s1_diff,
  output logic signed [W-1:0] s1_qsin
);

  localparam int WS = W + 2;

  fmt_e                fmt;
  logic                take;
  logic signed [WS-1:0] b_x;
  logic signed [WS-1:0] c_x;
  logic signed [WS-1:0] a_rebuilt;
  logic signed [W:0]   diff_cb;
  logic signed [W-1:0] cos_pick;

  assign fmt       = fmt_e'(fmt_sel);
  assign take      = smp_vld && fmt_ok(fmt);
  assign b_x       = WS'(ph_b);
  assign c_x       = WS'(ph_c);
  assign a_rebuilt = -(b_x + c_x);
  assign diff_cb   = (W+1)'(ph_c) - (W+1)'(ph_b);

  always_comb begin
    case (fmt)
      FMT_DUO: cos_pick = W'(sat_w(64'(a_rebuilt), W));
      default: cos_pick = ph_a;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_err  <= 1'b0;
      s1_fmt  <= FMT_NONE;
      s1_cos  <= '0;
      s1_diff <= '0;
      s1_qsin <= '0;
    end else begin
      s1_vld <= take;
      s1_err <= smp_vld && !fmt_ok(fmt);
      if (take) begin
        s1_fmt  <= fmt;
        s1_cos  <= cos_pick;
        s1_diff <= diff_cb;
        s1_qsin <= quad_sin;
      end
    end
  end

endmodule

// File: rtl/clarke_scale.sv
module clarke_scale
  import clarke_pkg::*;
#(
  parameter int W             = 16,
  parameter int FRAC          = 15,
  parameter int INV_SQRT3     = 18919,
  parameter bit ROUND_NEAREST = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s1_vld,
  input  logic                s1_err,
  input  fmt_e                s1_fmt,
  input  logic signed [W-1:0] s1_cos,
  input  logic signed [W:0]   s1_diff,
  input  logic signed [W-1:0] s1_qsin,
  output logic                orth_vld,
  output logic                fmt_err,
  output logic signed [W-1:0] orth_cos,
  output logic signed [W-1:0] orth_sin
);

  logic signed [63:0]  scaled;
  logic signed [W-1:0] sin_calc;
  logic signed [W-1:0] sin_pick;

  generate
    if (ROUND_NEAREST) begin : g_round
      assign scaled = mul_q(64'(s1_diff), 64'(INV_SQRT3), FRAC, 1'b1);
    end else begin : g_trunc
      assign scaled = mul_q(64'(s1_diff), 64'(INV_SQRT3), FRAC, 1'b0);
    end
  endgenerate

  assign sin_calc = W'(sat_w(scaled, W));
  assign sin_pick = (s1_fmt == FMT_QUAD) ? s1_qsin : sin_calc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      orth_vld <= 1'b0;
      fmt_err  <= 1'b0;
      orth_cos <= '0;
      orth_sin <= '0;
    end else begin
      orth_vld <= s1_vld;
      fmt_err  <= s1_err;
      if (s1_vld) begin
        orth_cos <= s1_cos;
        orth_sin <= sin_pick;
      end
    end
  end

endmodule

// File: rtl/clarke_cond.sv
module clarke_cond
  import clarke_pkg::*;
#(
  parameter int W             = 16,
  parameter int FRAC          = 15,
  parameter int INV_SQRT3     = 18919,
  parameter bit ROUND_NEAREST = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic [1:0]          fmt_sel,
  input  logic signed [W-1:0] ph_a,
  input  logic signed [W-1:0] ph_b,
  input  logic signed [W-1:0] ph_c,
  input  logic signed [W-1:0] quad_sin,
  output logic                orth_vld,
  output logic                fmt_err,
  output logic signed [W-1:0] orth_cos,
  output logic signed [W-1:0] orth_sin
);

  // Stage-one events, named so the checker can see them.
  logic                front_vld;
  logic                front_err;
  fmt_e                front_fmt;
  logic signed [W-1:0] front_cos;
  logic signed [W:0]   front_diff;
  logic signed [W-1:0] front_qsin;

  clarke_front #(.W(W)) u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (smp_vld),
    .fmt_sel  (fmt_sel),
    .ph_a     (ph_a),
    .ph_b     (ph_b),
    .ph_c     (ph_c),
    .quad_sin (quad_sin),
    .s1_vld   (front_vld),
    .s1_err   (front_err),
    .s1_fmt   (front_fmt),
    .s1_cos   (front_cos),
    .s1_diff  (front_diff),
    .s1_qsin  (front_qsin)
  );

  clarke_scale #(
    .W             (W),
    .FRAC          (FRAC),
    .INV_SQRT3     (INV_SQRT3),
    .ROUND_NEAREST (ROUND_NEAREST)
  ) u_scale (
    .clk      (clk),
    .rst_n    (rst_n),
    .s1_vld   (front_vld),
    .s1_err   (front_err),
    .s1_fmt   (front_fmt),
    .s1_cos   (front_cos),
    .s1_diff  (front_diff),
    .s1_qsin  (front_qsin),
    .orth_vld (orth_vld),
    .fmt_err  (fmt_err),
    .orth_cos (orth_cos),
    .orth_sin (orth_sin)
  );

endmodule

// File: rtl/clarke_cond_chk.sv
module clarke_cond_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_vld,
  input logic [1:0]          fmt_sel,
  input logic signed [W-1:0] ph_a,
  input logic signed [W-1:0] quad_sin,
  input logic                orth_vld,
  input logic                fmt_err,
  input logic signed [W-1:0] orth_cos,
  input logic signed [W-1:0] orth_sin,
  input logic                front_vld,
  input logic                front_err
);

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && fmt_sel != 2'b00) |-> ##2 orth_vld);

  a_r2_stage_one: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && fmt_sel != 2'b00) |=> front_vld);

  a_r2_stage_two: assert property (@(posedge clk) disable iff (!rst_n)
    front_vld |=> orth_vld);

  a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && fmt_sel == 2'b00) |-> ##2 (fmt_err && !orth_vld));

  a_r7_err_stage: assert property (@(posedge clk) disable iff (!rst_n)
    front_err |=> (fmt_err && !orth_vld));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |-> ##2 !(orth_vld || fmt_err));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !orth_vld |-> ($stable(orth_cos) && $stable(orth_sin)));

  a_r3_quad_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && fmt_sel == 2'b01) |-> ##2 (orth_cos == $past(ph_a, 2) && orth_sin == $past(quad_sin, 2)));

  a_r4_cos_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && fmt_sel == 2'b10) |-> ##2 (orth_cos == $past(ph_a, 2)));

endmodule

bind clarke_cond clarke_cond_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_vld   (smp_vld),
  .fmt_sel   (fmt_sel),
  .ph_a      (ph_a),
  .quad_sin  (quad_sin),
  .orth_vld  (orth_vld),
  .fmt_err   (fmt_err),
  .orth_cos  (orth_cos),
  .orth_sin  (orth_sin),
  .front_vld (front_vld),
  .front_err (front_err)
);

// File: tb/sim_clarke_cond.sv
`timescale 1ns/1ps
module sim_clarke_cond;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               smp_vld = 1'b0;
  logic [1:0]         fmt_sel = 2'b00;
  logic signed [15:0] ph_a = '0, ph_b = '0, ph_c = '0, quad_sin = '0;
  logic               orth_vld, fmt_err;
  logic signed [15:0] orth_cos, orth_sin;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  clarke_cond u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .fmt_sel(fmt_sel),
    .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c), .quad_sin(quad_sin),
    .orth_vld(orth_vld), .fmt_err(fmt_err), .orth_cos(orth_cos), .orth_sin(orth_sin)
  );

  // Expected-value pipeline, two entries deep.
  bit exp_v [2];
  bit exp_e [2];
  int exp_c [2];
  int exp_s [2];
  string exp_tag [2];
  int held_c = 0;
  int held_s = 0;

  function automatic int clamp16(longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return int'(x);
  endfunction

  // floor((d*18919 + 16384)/32768) written with explicit floor division
  function automatic int sin_from_diff(longint d);
    longint p, r;
    p = d * 18919 + 16384;
    r = p % 32768;
    if (r < 0) r = r + 32768;
    return clamp16((p - r) / 32768);
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(bit v, logic [1:0] f, int a, int b, int c, int s);
    bit nv, ne;
    int nc, ns;
    string tg;
    // compare what was driven two cycles ago
    check(exp_e[1] ? "R7" : "R2", "orth_vld", orth_vld, exp_v[1]);
    check(exp_v[1] ? "R2" : "R7", "fmt_err", fmt_err, exp_e[1]);
    if (exp_v[1]) begin
      held_c = exp_c[1];
      held_s = exp_s[1];
      check(exp_tag[1], "orth_cos", orth_cos, held_c);
      check(exp_tag[1], "orth_sin", orth_sin, held_s);
    end else begin
      check(exp_e[1] ? "R7" : "R8", "held orth_cos", orth_cos, held_c);
      check(exp_e[1] ? "R7" : "R8", "held orth_sin", orth_sin, held_s);
    end
    // expected result of the new sample
    nv = v && (f != 2'b00);
    ne = v && (f == 2'b00);
    nc = 0; ns = 0; tg = "R8";
    case (f)
      2'b01: begin nc = a; ns = s; tg = "R3"; end
      2'b10: begin nc = a; ns = sin_from_diff(longint'(c) - b); tg = "R4"; end
      2'b11: begin nc = clamp16(-(longint'(b) + c)); ns = sin_from_diff(longint'(c) - b); tg = "R5"; end
      default: ;
    endcase
    exp_v[1] = exp_v[0]; exp_e[1] = exp_e[0]; exp_c[1] = exp_c[0]; exp_s[1] = exp_s[0]; exp_tag[1] = exp_tag[0];
    exp_v[0] = nv; exp_e[0] = ne; exp_c[0] = nc; exp_s[0] = ns; exp_tag[0] = tg;
    smp_vld  = v;
    fmt_sel  = f;
    ph_a     = 16'(a);
    ph_b     = 16'(b);
    ph_c     = 16'(c);
    quad_sin = 16'(s);
    @(negedge clk);
  endtask

  function automatic int rnd16();
    int k;
    k = $urandom % 8;
    if (k == 0) return 32767;
    if (k == 1) return -32768;
    return int'(signed'(16'($urandom)));
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      exp_v[i] = 0; exp_e[i] = 0; exp_c[i] = 0; exp_s[i] = 0; exp_tag[i] = "R8";
    end
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R1: reset state while held in reset
    check("R1", "orth_vld in reset", orth_vld, 0);
    check("R1", "fmt_err in reset", fmt_err, 0);
    check("R1", "orth_cos in reset", orth_cos, 0);
    check("R1", "orth_sin in reset", orth_sin, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "orth_vld after reset", orth_vld, 0);
    check("R1", "orth_cos after reset", orth_cos, 0);

    // directed corner cases
    step(1, 2'b01, 1234, 777, -999, -4321);        // R3 quadrature pass
    step(1, 2'b10, 1000, -2000, 3000, 5);           // R4 three phase
    step(1, 2'b11, 5555, -32768, -32768, 9);        // R5/R6 rebuild clamps high
    step(1, 2'b11, 0, 32767, 32767, 0);             // R5 rebuild -65534 clamps low
    step(1, 2'b10, 0, -32768, 32767, 0);            // R6 sine clamps high
    step(1, 2'b10, 0, 32767, -32768, 0);            // R6 sine clamps low
    step(1, 2'b00, 111, 222, 333, 444);             // R7 invalid code
    step(0, 2'b10, -5, 6, -7, 8);                   // R8 idle junk
    step(0, 2'b01, 9, 9, 9, 9);                     // R8 idle junk
    step(1, 2'b11, 0, 1, 0, 0);                     // R4 rounding: -1/sqrt3 -> -1
    step(1, 2'b10, 0, 0, 1, 0);                     // R4 rounding: 1/sqrt3 -> 1
    step(0, 2'b00, 0, 0, 0, 0);
    step(0, 2'b00, 0, 0, 0, 0);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 5) != 0, 2'($urandom), rnd16(), rnd16(), rnd16(), rnd16());
    end
    step(0, 2'b00, 0, 0, 0, 0);
    step(0, 2'b00, 0, 0, 0, 0);
    step(0, 2'b00, 0, 0, 0, 0);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

endmodule